// File: doc/BRIEF.md
# Remote-Instruction Execute Sequencer

This block is the control sequencer behind the "execute the word at address M" opcode of a small 24-bit processor. The opcode is 023 octal. When the main decoder issues this opcode at program address l, the sequencer takes over. It reads the word at M through a memory read port and presents that word to the main decoder, which runs it in place of the current instruction. The program counter stays untouched while this happens. When the decoder reports that the target has completed, the sequencer works out where control goes next and loads the program counter exactly once.

The decoder classifies each target it runs as ordinary, branch, skip or execute. What happens next depends on that class:

- An ordinary target sends control to l+1.
- A branch sends control to the branch's effective address.
- A skip sends control to l+1 or l+2, depending on whether the skip is taken.
- A target that is itself an execute opcode starts another fetch from its own effective address. The chain keeps going until a non-execute target resolves it, and every return address is measured from the original l.

Indirect addressing and indexing are resolved upstream, so the addresses that arrive here are already effective. A depth counter bounds the chain: an execute chain that tries to nest past the limit ends with a trap pulse and no program-counter load.

Top module: `xeq_sequencer`

## Requirements
- R1: After reset, busy, mem_req, tgt_valid, pc_load and trap are all 0.
- R2: A chain starts only in a cycle where issue_valid is 1, issue_opcode equals 6'o23 and busy is 0. Any other opcode leaves busy and mem_req at 0.
- R3: One cycle after the issue cycle, mem_req is 1 and mem_addr equals issue_ea. In the cycle after that, tgt_valid is 1 and tgt_word carries the word returned on mem_rdata, which has a latency of one cycle.
- R4: While busy is 1, saved_pc holds the issuing address l and pc_load stays 0.
- R5: When dec_valid reports class 2'b00 (ordinary), the next cycle shows a single pc_load pulse with pc_next = l+1, and busy drops to 0 in that same cycle.
- R6: Class 2'b01 (branch) loads pc_next = dec_ea.
- R7: Class 2'b10 (skip) loads l+2 when dec_skip is 1 and l+1 when dec_skip is 0. The sum wraps modulo 2^AW.
- R8: Class 2'b11 (execute) produces no load. The next cycle fetches from dec_ea, and the final resolution is still measured from the original l.
- R9: A chain may accept up to MAX_DEPTH nested executes (default 255) and still resolve normally. One more nested execute ends the chain with a one-cycle trap pulse, busy at 0 and no pc_load.
- R10: An execute issue that arrives while busy is 1 is ignored, and saved_pc keeps its value.
- R11: dec_valid has no effect unless the sequencer is waiting for the target to complete, which is the cycle after tgt_valid or any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Decoder issues an instruction this cycle |
| issue_opcode | input | 6 | Opcode of the issued instruction |
| issue_pc | input | 14 | Address l of the issued instruction |
| issue_ea | input | 14 | Resolved effective address M |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 14 | Memory read address |
| mem_rdata | input | 24 | Read data, one cycle after the request |
| tgt_valid | output | 1 | Fetched target word valid for the decoder |
| tgt_word | output | 24 | Fetched target word |
| dec_valid | input | 1 | Decoder reports the target completed |
| dec_class | input | 2 | Target class: 00 ordinary, 01 branch, 10 skip, 11 execute |
| dec_ea | input | 14 | Target effective address (branch destination or next execute target) |
| dec_skip | input | 1 | Skip condition taken |
| busy | output | 1 | A chain is in progress |
| saved_pc | output | 14 | Held issuing address l |
| pc_load | output | 1 | One-cycle program-counter load strobe |
| pc_next | output | 14 | Address to load |
| trap | output | 1 | One-cycle pulse when the depth limit is exceeded |

## Verification
The assertions check several properties on every cycle:

- An idle sequencer makes no memory request and presents no target.
- Every request is followed by a valid target word.
- saved_pc stays constant for as long as busy is high.
- A load or a trap appears only with busy low, and a load is never two cycles long.
- The depth count never goes past its limit.

The return address for each target class cannot be seen from the invariants alone, so the bench's scenarios cover it. The same goes for the wrap of l+2, the origin of the address inside nested chains, the exact boundary between MAX_DEPTH and MAX_DEPTH+1 nested executes, and the rejection of early completion reports and of issues that arrive mid-chain.

// File: rtl/xeq_pkg.sv
package xeq_pkg;
  localparam logic [5:0] OPC_EXECUTE = 6'o23;

  typedef enum logic [1:0] {
    CLS_PLAIN  = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_SKIP   = 2'b10,
    CLS_EXEC   = 2'b11
  } xeq_class_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_FETCH = 2'b01,
    ST_DATA  = 2'b10,
    ST_RUN   = 2'b11
  } xeq_state_e;
endpackage

// File: rtl/xeq_depth.sv
module xeq_depth #(
  parameter int MAX_DEPTH = 255,
  localparam int DEPTH_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  logic [DEPTH_W-1:0] depth_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   depth_q <= '0;
    else if (clr) depth_q <= '0;
    else if (inc) depth_q <= depth_q + 1'b1;
  end

  assign at_limit = (depth_q == DEPTH_W'(MAX_DEPTH));

  a_r9_depth_cap: assert property (@(posedge clk) disable iff (!rst_n)
    at_limit |-> !inc);
  a_r9_depth_range: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEPTH_W'(MAX_DEPTH));
endmodule

// File: rtl/xeq_resolve.sv
module xeq_resolve
  import xeq_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic [AW-1:0] saved_pc,
  input  logic [1:0]    dec_class,
  input  logic [AW-1:0] dec_ea,
  input  logic          dec_skip,
  output logic [AW-1:0] res_pc,
  output logic          res_final
);
  function automatic logic [AW-1:0] seq_return(input logic [AW-1:0] base,
                                               input logic take_skip);
    return base + (take_skip ? AW'(2) : AW'(1));
  endfunction

  xeq_class_e cls;
  assign cls = xeq_class_e'(dec_class);

  always_comb begin
    res_final = 1'b1;
    res_pc    = seq_return(saved_pc, 1'b0);
    case (cls)
      CLS_PLAIN:  res_pc = seq_return(saved_pc, 1'b0);
      CLS_BRANCH: res_pc = dec_ea;
      CLS_SKIP:   res_pc = seq_return(saved_pc, dec_skip);
      CLS_EXEC: begin
        res_pc    = dec_ea;
        res_final = 1'b0;
      end
      default:    res_final = 1'b1;
    endcase
  end
endmodule

// File: rtl/xeq_ctrl.sv
module xeq_ctrl
  import xeq_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_pc,
  input  logic [AW-1:0] start_ea,
  input  logic          dec_valid,
  input  logic [AW-1:0] dec_ea,
  input  logic          res_final,
  input  logic [AW-1:0] res_pc,
  input  logic          at_limit,
  output logic          busy,
  output logic          fetch,
  output logic          data_ok,
  output logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] saved_pc,
  output logic          chain_inc,
  output logic          pc_load,
  output logic [AW-1:0] pc_next,
  output logic          trap
);
  xeq_state_e state_q;
  logic [AW-1:0] saved_q, addr_q, next_q;
  logic load_q, trap_q;
  logic accept;

  assign accept    = (state_q == ST_RUN) && dec_valid;
  assign chain_inc = accept && !res_final && !at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      saved_q <= '0;
      addr_q  <= '0;
      next_q  <= '0;
      load_q  <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      load_q <= 1'b0;
      trap_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          saved_q <= start_pc;
          addr_q  <= start_ea;
          state_q <= ST_FETCH;
        end
        ST_FETCH: state_q <= ST_DATA;
        ST_DATA:  state_q <= ST_RUN;
        ST_RUN: if (accept) begin
          if (res_final) begin
            load_q  <= 1'b1;
            next_q  <= res_pc;
            state_q <= ST_IDLE;
          end else if (at_limit) begin
            trap_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            addr_q  <= dec_ea;
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign fetch      = (state_q == ST_FETCH);
  assign data_ok    = (state_q == ST_DATA);
  assign fetch_addr = addr_q;
  assign saved_pc   = saved_q;
  assign pc_load    = load_q;
  assign pc_next    = next_q;
  assign trap       = trap_q;

  a_r3_fetch_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> data_ok);
  a_r4_saved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(saved_pc));
  a_r4_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> !busy);
  a_r5_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);
  a_r9_trap_alone: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (!pc_load && !busy));
endmodule

// File: rtl/xeq_sequencer.sv
module xeq_sequencer
  import xeq_pkg::*;
#(
  parameter int AW        = 14,
  parameter int DW        = 24,
  parameter int OPW       = 6,
  parameter int MAX_DEPTH = 255
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue_valid,
  input  logic [OPW-1:0] issue_opcode,
  input  logic [AW-1:0]  issue_pc,
  input  logic [AW-1:0]  issue_ea,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic [DW-1:0]  mem_rdata,
  output logic           tgt_valid,
  output logic [DW-1:0]  tgt_word,
  input  logic           dec_valid,
  input  logic [1:0]     dec_class,
  input  logic [AW-1:0]  dec_ea,
  input  logic           dec_skip,
  output logic           busy,
  output logic [AW-1:0]  saved_pc,
  output logic           pc_load,
  output logic [AW-1:0]  pc_next,
  output logic           trap
);
  logic exec_hit, start;
  logic res_final, at_limit, chain_inc;
  logic [AW-1:0] res_pc;

  assign exec_hit = issue_valid && (issue_opcode == OPW'(OPC_EXECUTE));
  assign start    = exec_hit && !busy;

  xeq_resolve #(.AW(AW)) u_resolve (
    .saved_pc (saved_pc),
    .dec_class(dec_class),
    .dec_ea   (dec_ea),
    .dec_skip (dec_skip),
    .res_pc   (res_pc),
    .res_final(res_final)
  );

  xeq_depth #(.MAX_DEPTH(MAX_DEPTH)) u_depth (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start),
    .inc     (chain_inc),
    .at_limit(at_limit)
  );

  xeq_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_pc  (issue_pc),
    .start_ea  (issue_ea),
    .dec_valid (dec_valid),
    .dec_ea    (dec_ea),
    .res_final (res_final),
    .res_pc    (res_pc),
    .at_limit  (at_limit),
    .busy      (busy),
    .fetch     (mem_req),
    .data_ok   (tgt_valid),
    .fetch_addr(mem_addr),
    .saved_pc  (saved_pc),
    .chain_inc (chain_inc),
    .pc_load   (pc_load),
    .pc_next   (pc_next),
    .trap      (trap)
  );

  assign tgt_word = mem_rdata;

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !tgt_valid));
  a_r10_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_hit && busy) |=> $stable(saved_pc));
endmodule

// File: tb/xeq_sequencer_tb.sv
module xeq_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 14;
  localparam int DW = 24;
  localparam int MAXD = 255;

  logic clk = 0, rst_n = 0;
  logic issue_valid = 0;
  logic [5:0] issue_opcode = 0;
  logic [AW-1:0] issue_pc = 0, issue_ea = 0;
  logic mem_req, tgt_valid, busy, pc_load, trap;
  logic [AW-1:0] mem_addr, saved_pc, pc_next;
  logic [DW-1:0] mem_rdata = 0, tgt_word;
  logic dec_valid = 0, dec_skip = 0;
  logic [1:0] dec_class = 0;
  logic [AW-1:0] dec_ea = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xeq_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_opcode(issue_opcode),
    .issue_pc(issue_pc), .issue_ea(issue_ea), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .tgt_valid(tgt_valid), .tgt_word(tgt_word),
    .dec_valid(dec_valid), .dec_class(dec_class), .dec_ea(dec_ea), .dec_skip(dec_skip),
    .busy(busy), .saved_pc(saved_pc), .pc_load(pc_load), .pc_next(pc_next), .trap(trap)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a[9:0] ^ 10'h2A5, a};
  endfunction

  always @(posedge clk) if (mem_req) mem_rdata <= mem_word(mem_addr);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] op, input logic [AW-1:0] l, input logic [AW-1:0] m);
    issue_valid = 1; issue_opcode = op; issue_pc = l; issue_ea = m;
    @(negedge clk);
    issue_valid = 0;
  endtask

  // One target: fetch at m, report class; ends with dec cleared at the following negedge
  task automatic step(input logic [AW-1:0] m, input logic [AW-1:0] l,
                      input logic [1:0] cls, input logic [AW-1:0] ea, input logic sk);
    check("R3 mem_req", mem_req, 1);
    check("R3 mem_addr", mem_addr, m);
    @(negedge clk);
    check("R3 tgt_valid", tgt_valid, 1);
    check("R3 tgt_word", tgt_word, mem_word(m));
    check("R4 saved_pc", saved_pc, l);
    check("R4 no load", pc_load, 0);
    @(negedge clk);
    dec_valid = 1; dec_class = cls; dec_ea = ea; dec_skip = sk;
    @(negedge clk);
    dec_valid = 0; dec_skip = 0;
  endtask

  task automatic expect_load(input string tag, input logic [AW-1:0] exp);
    check({tag, " pc_load"}, pc_load, 1);
    check({tag, " pc_next"}, pc_next, exp);
    check({tag, " busy low"}, busy, 0);
    @(negedge clk);
    check({tag, " pulse ends"}, pc_load, 0);
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 tgt_valid", tgt_valid, 0);
    check("R1 pc_load", pc_load, 0);
    check("R1 trap", trap, 0);
  endtask

  task automatic t_other_opcode();
    issue(6'o22, 14'd100, 14'd200);
    check("R2 busy stays 0", busy, 0);
    check("R2 no mem_req", mem_req, 0);
    @(negedge clk);
    check("R2 still idle", busy, 0);
  endtask

  task automatic t_plain();
    issue(6'o23, 14'd100, 14'd500);
    check("R2 busy", busy, 1);
    step(14'd500, 14'd100, 2'b00, 14'd0, 0);
    expect_load("R5", 14'd101);
  endtask

  task automatic t_branch();
    issue(6'o23, 14'd300, 14'd40);
    step(14'd40, 14'd300, 2'b01, 14'd9000, 0);
    expect_load("R6", 14'd9000);
  endtask

  task automatic t_skip();
    issue(6'o23, 14'd700, 14'd41);
    step(14'd41, 14'd700, 2'b10, 14'd5, 0);
    expect_load("R7 no skip", 14'd701);
    issue(6'o23, 14'd700, 14'd42);
    step(14'd42, 14'd700, 2'b10, 14'd5, 1);
    expect_load("R7 skip", 14'd702);
    issue(6'o23, 14'h3FFF, 14'd43);
    step(14'd43, 14'h3FFF, 2'b10, 14'd5, 1);
    expect_load("R7 wrap", 14'd1);
  endtask

  task automatic t_nested();
    issue(6'o23, 14'd1000, 14'd60);
    step(14'd60, 14'd1000, 2'b11, 14'd61, 0);
    check("R8 no load", pc_load, 0);
    check("R8 busy", busy, 1);
    step(14'd61, 14'd1000, 2'b11, 14'd62, 0);
    step(14'd62, 14'd1000, 2'b10, 14'd3, 1);
    expect_load("R8 final from l", 14'd1002);
  endtask

  task automatic t_busy_issue();
    issue(6'o23, 14'd20, 14'd70);
    check("R3 mem_req", mem_req, 1);
    issue(6'o23, 14'd999, 14'd888);
    check("R10 saved_pc kept", saved_pc, 14'd20);
    check("R10 tgt_valid", tgt_valid, 1);
    @(negedge clk);
    dec_valid = 1; dec_class = 2'b00;
    @(negedge clk);
    dec_valid = 0;
    expect_load("R10 original l", 14'd21);
    check("R10 no new chain", busy, 0);
  endtask

  task automatic t_early_dec();
    issue(6'o23, 14'd50, 14'd80);
    dec_valid = 1; dec_class = 2'b01; dec_ea = 14'd7;
    @(negedge clk);
    check("R11 early dec busy", busy, 1);
    check("R11 tgt_valid", tgt_valid, 1);
    @(negedge clk);
    dec_valid = 0;
    check("R11 no load", pc_load, 0);
    check("R11 still busy", busy, 1);
    dec_valid = 1; dec_class = 2'b00;
    @(negedge clk);
    dec_valid = 0;
    expect_load("R11 normal resolve", 14'd51);
  endtask

  task automatic t_depth_ok();
    issue(6'o23, 14'd2000, 14'd100);
    for (int i = 0; i < MAXD; i++)
      step(14'(100 + i), 14'd2000, 2'b11, 14'(101 + i), 0);
    check("R9 busy at limit", busy, 1);
    step(14'(100 + MAXD), 14'd2000, 2'b00, 14'd0, 0);
    check("R9 no trap at limit", trap, 0);
    expect_load("R9 limit resolves", 14'd2001);
  endtask

  task automatic t_depth_trap();
    issue(6'o23, 14'd3000, 14'd10);
    for (int i = 0; i < MAXD; i++)
      step(14'd10, 14'd3000, 2'b11, 14'd10, 0);
    step(14'd10, 14'd3000, 2'b11, 14'd10, 0);
    check("R9 trap", trap, 1);
    check("R9 trap no load", pc_load, 0);
    check("R9 trap busy", busy, 0);
    @(negedge clk);
    check("R9 trap pulse", trap, 0);
    check("R9 idle after trap", mem_req, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_other_opcode();
    t_plain();
    t_branch();
    t_skip();
    t_nested();
    t_busy_issue();
    t_early_dec();
    t_depth_ok();
    t_depth_trap();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule